// File: doc/BRIEF.md
# Smart switch fault supervisor

This block is the digital supervisor of a two-channel high-side power switch. Each channel has a logic command input. One shared active-low fault-clear / standby pin is also provided. Per channel, the block samples digitized condition flags: overtemperature, overload or short to ground, and output-above-threshold while off. It also samples one shared undervoltage flag. From these it drives a gate enable and a two-bit sense-mode code for each channel. The analog parts (current mirror, thermal sensor, current limit, clamps) live outside and appear only as these flags and codes.

The shared pin selects the protection policy. When the pin is high, a fault on an enabled channel latches the channel off until a qualified low pulse on the pin clears it. When the pin is low, the channel restarts by itself once the fault flag drops. The same pin enables off-state diagnostics. When it is low and every command input is low for a set time, the block goes into standby, which also wipes any latch. All delays are parameters in clock cycles, and every asynchronous input passes through a synchronizer first.

Each channel runs a state machine with four states: CH_OFF, CH_ON, CH_COOL (off while a fault flag is set, restarting by itself) and CH_LATCH. Its transitions are:
- OFF to ON when the command is high and undervoltage is absent.
- ON to OFF when the command drops or undervoltage appears.
- ON to LATCH on a fault with the pin high.
- ON to COOL on a fault with the pin low.
- COOL to ON when the fault flag clears.
- COOL to LATCH if the pin rises while the fault persists.
- COOL to OFF when the command drops.
- LATCH to OFF on a clear pulse.
- Any state to OFF on standby.

The shared mode machine has three states: MD_RUN, MD_WAIT (all low, timer running) and MD_STBY. Its transitions are:
- RUN to WAIT when everything is low.
- WAIT to STBY when the timer ends.
- WAIT or STBY back to RUN on the first high input.

Top module: `hsw_fault_supervisor`

## Requirements
- R1: With the command high, no fault and no undervoltage, the gate is on and the sense code is 01 (proportional). With the command low and no diagnostic report, the gate is off and the code is 00 (silent). After reset, all gates are off and all codes are 00.
- R2: With the shared pin high, an overtemperature or overload flag on an enabled channel turns its gate off and keeps it off after the flag clears. While latched, the code is 10 (fault level) when the command is high and 00 when it is low.
- R3: A latch is cleared only by a low pulse on the shared pin lasting at least RST_CYC synchronized cycles, and the clear acts on the pin's rising edge. A shorter pulse leaves the latch in place. If the fault flag is still set when the channel turns back on, the latch forms again.
- R4: With the shared pin low, a fault on an enabled channel turns the gate off with code 10. When the flag clears, the gate is on again with code 01, without any clear pulse.
- R5: When every command input and the shared pin stay low for STBY_CYC cycles, the block enters standby. In standby all gates are off, all codes are 00 and all latches are wiped. A shorter idle period wipes nothing. Standby ends on the first cycle that any of these inputs is high.
- R6: Undervoltage forces every gate off and every code to 00, whatever the other inputs are.
- R7: With the command low and the output-above-threshold flag set, the code is 10 only while the shared pin is high. While the pin is low, the code is 00.
- R8: The off-state report appears no sooner than a detection delay. After the command falls, the delay is STK_CYC cycles. After the shared pin rises while the command is low, it is the shorter FRST_CYC cycles.
- R9: The sense code only ever takes the values 00, 01 or 10. It is 01 whenever the gate is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_in | input | NCH | Per-channel command input (asynchronous) |
| frst_in | input | 1 | Shared fault-clear / standby pin, low active (asynchronous) |
| ovt_flag | input | NCH | Per-channel overtemperature flag |
| ovl_flag | input | NCH | Per-channel overload / short-to-ground flag |
| ohi_flag | input | NCH | Per-channel output-above-threshold-while-off flag |
| uv_flag | input | 1 | Shared supply undervoltage flag |
| gate_en | output | NCH | Per-channel gate enable |
| sense_mode | output | 2*NCH | Per-channel sense code, bits [2i+1:2i]: 00 silent, 01 proportional, 10 fault level |

## Verification
The hardest case to reach from the ports is telling standby apart from an ordinary idle period. Both show gates off and silent codes, so the only visible difference is whether a latch survives. The stimulus first latches a channel, then idles everything for less than the standby delay and for more than it. After each idle period it raises the command while keeping the shared pin low, which rules out a clear pulse, and observes whether the channel comes back on. The detection delays and the pulse-width qualification are probed the same way, by sampling before and after the programmed window. A seeded random phase then sweeps steady-state mixes of commands, pin level, diagnostic flag and undervoltage.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    typedef enum logic [1:0] {
        SNS_SILENT = 2'b00,
        SNS_PROP   = 2'b01,
        SNS_FAULT  = 2'b10
    } sense_e;

    typedef enum logic [1:0] {
        CH_OFF   = 2'b00,
        CH_ON    = 2'b01,
        CH_COOL  = 2'b10,
        CH_LATCH = 2'b11
    } ch_state_e;

    typedef enum logic [1:0] {
        MD_RUN  = 2'b00,
        MD_WAIT = 2'b01,
        MD_STBY = 2'b10
    } mode_e;

endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hsw_mode_ctrl.sv
module hsw_mode_ctrl
    import hsw_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int CNT_W    = 16,
    parameter int RST_CYC  = 200,
    parameter int STBY_CYC = 12000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] in_s,
    input  logic           frst_s,
    output logic           stby_o,
    output logic           clr_o
);
    localparam logic [CNT_W-1:0] STBY_L = CNT_W'(STBY_CYC - 1);
    localparam logic [CNT_W-1:0] RST_L  = CNT_W'(RST_CYC);

    mode_e            md_q, md_d;
    logic [CNT_W-1:0] idle_cnt;
    logic [CNT_W-1:0] low_cnt;
    logic             frst_q;
    logic             any_hi;

    assign any_hi = (|in_s) | frst_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) md_q <= MD_RUN;
        else        md_q <= md_d;
    end

    always_comb begin
        md_d = md_q;
        unique case (md_q)
            MD_RUN:  if (!any_hi) md_d = MD_WAIT;
            MD_WAIT: if (any_hi) md_d = MD_RUN;
                     else if (idle_cnt == '0) md_d = MD_STBY;
            MD_STBY: if (any_hi) md_d = MD_RUN;
            default: md_d = MD_RUN;
        endcase
    end

    // idle timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 idle_cnt <= STBY_L;
        else if (md_q != MD_WAIT)   idle_cnt <= STBY_L;
        else if (idle_cnt != '0)    idle_cnt <= idle_cnt - 1'b1;
    end

    // clear-pulse qualifier: counts low cycles, fires on the rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            frst_q  <= 1'b1;
        end else begin
            frst_q <= frst_s;
            if (frst_s)                low_cnt <= '0;
            else if (low_cnt != RST_L) low_cnt <= low_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        stby_o = (md_q == MD_STBY);
        clr_o  = frst_s & ~frst_q & (low_cnt == RST_L);
    end
endmodule

// File: rtl/hsw_chan.sv
module hsw_chan
    import hsw_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int STK_CYC  = 18000,
    parameter int FRST_CYC = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_s,
    input  logic       frst_s,
    input  logic       ovt_s,
    input  logic       ovl_s,
    input  logic       ohi_s,
    input  logic       uv_s,
    input  logic       stby,
    input  logic       clr,
    output logic       gate_o,
    output logic [1:0] sense_o,
    output logic       latched_o
);
    localparam logic [CNT_W-1:0] STK_L  = CNT_W'(STK_CYC);
    localparam logic [CNT_W-1:0] FRST_L = CNT_W'(FRST_CYC);

    ch_state_e        st_q, st_d;
    logic [CNT_W-1:0] diag_cnt;
    logic             flt;
    logic             diag_hit;

    assign flt = ovt_s | ovl_s;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (stby) begin
            st_d = CH_OFF;
        end else begin
            unique case (st_q)
                CH_OFF:   if (in_s && !uv_s) st_d = CH_ON;
                CH_ON:    if (uv_s || !in_s) st_d = CH_OFF;
                          else if (flt) st_d = frst_s ? CH_LATCH : CH_COOL;
                CH_COOL:  if (uv_s || !in_s) st_d = CH_OFF;
                          else if (flt && frst_s) st_d = CH_LATCH;
                          else if (!flt) st_d = CH_ON;
                CH_LATCH: if (clr) st_d = CH_OFF;
                default:  st_d = CH_OFF;
            endcase
        end
    end

    // off-state detection delay: long after a turn-off, short after pin rise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  diag_cnt <= FRST_L;
        else if (st_q != CH_OFF)     diag_cnt <= STK_L;
        else if (!frst_s)            diag_cnt <= FRST_L;
        else if (diag_cnt != '0)     diag_cnt <= diag_cnt - 1'b1;
    end

    assign diag_hit = frst_s & ohi_s & (diag_cnt == '0);

    // outputs
    always_comb begin
        gate_o    = 1'b0;
        sense_o   = SNS_SILENT;
        latched_o = (st_q == CH_LATCH);
        if (!(uv_s || stby)) begin
            unique case (st_q)
                CH_OFF:   sense_o = diag_hit ? SNS_FAULT : SNS_SILENT;
                CH_ON:    begin gate_o = 1'b1; sense_o = SNS_PROP; end
                CH_COOL:  sense_o = SNS_FAULT;
                CH_LATCH: sense_o = in_s ? SNS_FAULT : SNS_SILENT;
                default:  sense_o = SNS_SILENT;
            endcase
        end
    end
endmodule

// File: rtl/hsw_fault_supervisor.sv
module hsw_fault_supervisor
    import hsw_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2,
    parameter int RST_CYC     = 200,
    parameter int STBY_CYC    = 12000,
    parameter int STK_CYC     = 18000,
    parameter int FRST_CYC    = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   chan_in,
    input  logic             frst_in,
    input  logic [NCH-1:0]   ovt_flag,
    input  logic [NCH-1:0]   ovl_flag,
    input  logic [NCH-1:0]   ohi_flag,
    input  logic             uv_flag,
    output logic [NCH-1:0]   gate_en,
    output logic [2*NCH-1:0] sense_mode
);
    localparam int M1    = (STBY_CYC > STK_CYC) ? STBY_CYC : STK_CYC;
    localparam int M2    = (FRST_CYC > RST_CYC) ? FRST_CYC : RST_CYC;
    localparam int MAXC  = (M1 > M2) ? M1 : M2;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int SW    = 4*NCH + 2;

    logic [SW-1:0]  raw, syn;
    logic [NCH-1:0] in_s, ovt_s, ovl_s, ohi_s;
    logic           frst_s, uv_s;
    logic           stby_active, clr_pulse;
    logic [NCH-1:0] ch_latched;

    assign raw = {uv_flag, frst_in, ohi_flag, ovl_flag, ovt_flag, chan_in};

    hsw_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    assign in_s   = syn[NCH-1:0];
    assign ovt_s  = syn[2*NCH-1:NCH];
    assign ovl_s  = syn[3*NCH-1:2*NCH];
    assign ohi_s  = syn[4*NCH-1:3*NCH];
    assign frst_s = syn[4*NCH];
    assign uv_s   = syn[4*NCH+1];

    hsw_mode_ctrl #(
        .NCH(NCH), .CNT_W(CNT_W), .RST_CYC(RST_CYC), .STBY_CYC(STBY_CYC)
    ) u_mode (
        .clk(clk), .rst_n(rst_n), .in_s(in_s), .frst_s(frst_s),
        .stby_o(stby_active), .clr_o(clr_pulse)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        hsw_chan #(
            .CNT_W(CNT_W), .STK_CYC(STK_CYC), .FRST_CYC(FRST_CYC)
        ) u_ch (
            .clk(clk), .rst_n(rst_n),
            .in_s(in_s[i]), .frst_s(frst_s),
            .ovt_s(ovt_s[i]), .ovl_s(ovl_s[i]), .ohi_s(ohi_s[i]),
            .uv_s(uv_s), .stby(stby_active), .clr(clr_pulse),
            .gate_o(gate_en[i]), .sense_o(sense_mode[2*i +: 2]),
            .latched_o(ch_latched[i])
        );
    end
endmodule

// File: rtl/hsw_fault_supervisor_chk.sv
module hsw_fault_supervisor_chk #(
    parameter int NCH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             uv_flag,
    input logic [NCH-1:0]   gate_en,
    input logic [2*NCH-1:0] sense_mode,
    input logic [NCH-1:0]   latched,
    input logic             clr,
    input logic             stby
);
    logic [1:0] cyc;
    logic       ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cyc <= '0;
        else if (cyc != 2'd3) cyc <= cyc + 1'b1;
    end
    assign ready = (cyc == 2'd3);

    // R6: undervoltage seen through the synchronizer forces everything quiet
    a_r6_uv_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(uv_flag, 2)) |-> (gate_en == '0 && sense_mode == '0));

    // R5: standby keeps every channel quiet
    a_r5_stby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        stby |-> (gate_en == '0 && sense_mode == '0));

    for (genvar i = 0; i < NCH; i++) begin : g_a
        // R9: no illegal sense code
        a_r9_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
            sense_mode[2*i +: 2] != 2'b11);
        // R9: gate on implies proportional sensing
        a_r9_gate_prop: assert property (@(posedge clk) disable iff (!rst_n)
            gate_en[i] |-> sense_mode[2*i +: 2] == 2'b01);
        // R2: a latched channel never drives its gate
        a_r2_latch_off: assert property (@(posedge clk) disable iff (!rst_n)
            latched[i] |-> !gate_en[i]);
        // R3: only a clear pulse or standby releases a latch
        a_r3_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (latched[i] && !clr && !stby) |=> latched[i]);
    end
endmodule

bind hsw_fault_supervisor hsw_fault_supervisor_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .gate_en(gate_en),
    .sense_mode(sense_mode), .latched(ch_latched), .clr(clr_pulse),
    .stby(stby_active)
);

// File: tb/hsw_fault_supervisor_bench.sv
module hsw_fault_supervisor_bench;
    localparam int NCH = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NCH-1:0]   chan_in = '0;
    logic             frst_in = 1'b0;
    logic [NCH-1:0]   ovt_flag = '0;
    logic [NCH-1:0]   ovl_flag = '0;
    logic [NCH-1:0]   ohi_flag = '0;
    logic             uv_flag = 1'b0;
    logic [NCH-1:0]   gate_en;
    logic [2*NCH-1:0] sense_mode;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #5 clk = ~clk;

    hsw_fault_supervisor #(
        .NCH(NCH), .SYNC_STAGES(2), .RST_CYC(4), .STBY_CYC(20),
        .STK_CYC(40), .FRST_CYC(8)
    ) u_hsw_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .chan_in(chan_in), .frst_in(frst_in),
        .ovt_flag(ovt_flag), .ovl_flag(ovl_flag), .ohi_flag(ohi_flag),
        .uv_flag(uv_flag), .gate_en(gate_en), .sense_mode(sense_mode)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int ch, input logic eg,
                       input logic [1:0] es);
        n_cmp++;
        if (gate_en[ch] !== eg || sense_mode[2*ch +: 2] !== es) begin
            n_bad++;
            $display("FAIL %s ch%0d: actual gate=%0b sense=%02b, expected gate=%0b sense=%02b",
                     req, ch, gate_en[ch], sense_mode[2*ch +: 2], eg, es);
        end
    endtask

    // steady-state expectation without any active fault flag
    function automatic logic [2:0] exp_steady(input logic cin, input logic fr,
                                              input logic ohi, input logic uv);
        if (uv)            return 3'b0_00;
        else if (cin)      return 3'b1_01;
        else if (fr && ohi) return 3'b0_10;
        else               return 3'b0_00;
    endfunction

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [2:0] e;
        void'($urandom(32'h5EED_0042));
        tick(5);
        chk("R1 reset", 0, 1'b0, 2'b00);
        chk("R1 reset", 1, 1'b0, 2'b00);
        rst_n = 1'b1;

        // R1 normal operation
        frst_in = 1'b1; chan_in = 2'b11; tick(8);
        chk("R1 on", 0, 1'b1, 2'b01);
        chk("R1 on", 1, 1'b1, 2'b01);
        chan_in = 2'b01; tick(8);
        chk("R1 off", 1, 1'b0, 2'b00);
        chk("R1 on", 0, 1'b1, 2'b01);

        // R2 latch-off
        ovt_flag[0] = 1'b1; tick(8);
        chk("R2 latch", 0, 1'b0, 2'b10);
        ovt_flag[0] = 1'b0; tick(20);
        chk("R2 latch held", 0, 1'b0, 2'b10);
        chan_in[0] = 1'b0; tick(8);
        chk("R2 latched input low", 0, 1'b0, 2'b00);
        chan_in[0] = 1'b1; tick(8);
        chk("R2 latched input high", 0, 1'b0, 2'b10);

        // R3 qualified clear
        frst_in = 1'b0; tick(2); frst_in = 1'b1; tick(10);
        chk("R3 short pulse ignored", 0, 1'b0, 2'b10);
        frst_in = 1'b0; tick(10); frst_in = 1'b1; tick(10);
        chk("R3 clear", 0, 1'b1, 2'b01);
        ovl_flag[0] = 1'b1; tick(8);
        chk("R3 overload latch", 0, 1'b0, 2'b10);
        frst_in = 1'b0; tick(10); frst_in = 1'b1; tick(12);
        chk("R3 relatch", 0, 1'b0, 2'b10);
        ovl_flag[0] = 1'b0; tick(8);
        frst_in = 1'b0; tick(10); frst_in = 1'b1; tick(10);
        chk("R3 clear after fault gone", 0, 1'b1, 2'b01);

        // R4 restart cycling
        frst_in = 1'b0; tick(4);
        ovt_flag[0] = 1'b1; tick(8);
        chk("R4 cycling off", 0, 1'b0, 2'b10);
        ovt_flag[0] = 1'b0; tick(8);
        chk("R4 cycling back on", 0, 1'b1, 2'b01);
        ovl_flag[0] = 1'b1; tick(8);
        chk("R4 overload off", 0, 1'b0, 2'b10);
        ovl_flag[0] = 1'b0; tick(8);
        chk("R4 overload back on", 0, 1'b1, 2'b01);

        // R5 standby wipes latches, short idle does not
        frst_in = 1'b1; tick(4);
        ovt_flag[0] = 1'b1; tick(8);
        chk("R5 setup latch", 0, 1'b0, 2'b10);
        ovt_flag[0] = 1'b0;
        chan_in = 2'b00; frst_in = 1'b0; tick(10);
        chan_in = 2'b01; tick(8);
        chk("R5 short idle keeps latch", 0, 1'b0, 2'b10);
        chan_in = 2'b00; tick(40);
        chk("R5 standby quiet", 0, 1'b0, 2'b00);
        chan_in = 2'b01; tick(8);
        chk("R5 latch wiped", 0, 1'b1, 2'b01);

        // R6 undervoltage
        frst_in = 1'b1; chan_in = 2'b11; tick(8);
        uv_flag = 1'b1; tick(6);
        chk("R6 uv", 0, 1'b0, 2'b00);
        chk("R6 uv", 1, 1'b0, 2'b00);
        uv_flag = 1'b0; tick(8);
        chk("R6 uv released", 0, 1'b1, 2'b01);
        chk("R6 uv released", 1, 1'b1, 2'b01);

        // R7 / R8 off-state diagnostics
        ohi_flag = 2'b11; chan_in = 2'b00; tick(20);
        chk("R8 before turn-off delay", 0, 1'b0, 2'b00);
        chk("R8 before turn-off delay", 1, 1'b0, 2'b00);
        tick(30);
        chk("R7 report", 0, 1'b0, 2'b10);
        chk("R8 after turn-off delay", 1, 1'b0, 2'b10);
        frst_in = 1'b0; tick(6);
        chk("R7 gated by pin low", 0, 1'b0, 2'b00);
        frst_in = 1'b1; tick(4);
        chk("R8 before pin-rise delay", 0, 1'b0, 2'b00);
        tick(10);
        chk("R8 after pin-rise delay", 0, 1'b0, 2'b10);
        ohi_flag = 2'b00;

        // random steady-state sweep
        for (int it = 0; it < 50; it++) begin
            chan_in  = NCH'($urandom);
            frst_in  = 1'($urandom);
            ohi_flag = NCH'($urandom);
            uv_flag  = (($urandom % 8) == 0);
            tick(60);
            for (int c = 0; c < NCH; c++) begin
                e = exp_steady(chan_in[c], frst_in, ohi_flag[c], uv_flag);
                chk("R1/R6/R7 random", c, e[2], e[1:0]);
            end
            n_cmp++;
            if (sense_mode[1:0] == 2'b11 || sense_mode[3:2] == 2'b11) begin
                n_bad++;
                $display("FAIL R9: actual sense=%04b, expected no 11 code", sense_mode);
            end
        end

        done = 1;
        summary();
        $finish;
    end
endmodule